// File: doc/BRIEF.md
# Power-Up Configuration Loader

This block runs once after every reset and brings a working register file to its start-up values. It reads a nonvolatile memory of 256 words by 16 bits through a synchronous read port with one cycle of latency. The memory counts as programmed only when a signature word holds a fixed code. When the memory is programmed, the block copies selected configuration words, each to the working register at the same address, through a plain write port (address, data, strobe). When the signature is missing, nothing is written and the registers keep whatever their own reset gave them. A done flag tells the rest of the chip that start-up loading is over. No host command is needed.

The copy covers two ranges. Addresses 0x10 to 0x1F are copied unconditionally. Addresses 0x2C to 0x33 are copied one word at a time, and only when bit 15 of that stored word is 1. The table area, addresses 64 to 255, is never read. Writes to the working registers never reach the memory.

The sequencer is a single state machine. Its states are ST_IDLE (entered on reset), ST_SIG_REQ (signature read issued), ST_SIG_CHK (signature compared), ST_CP_REQ (word read issued), ST_CP_WR (word written or skipped) and ST_DONE (terminal). Its transitions are: IDLE to SIG_REQ always; SIG_REQ to SIG_CHK always; SIG_CHK to CP_REQ on a match, otherwise to DONE; CP_REQ to CP_WR always; CP_WR back to CP_REQ unless the word was 0x33, in which case it goes to DONE; DONE stays in DONE until reset. After word 0x1F, the next address is 0x2C.

Top module: `nv_boot_loader`

## Requirements
- R1: The first memory read after reset is at address 0x37. No register write happens before that word has been compared.
- R2: If the word at 0x37 is not exactly 0xAA55, no register write happens and the load ends.
- R3: If the signature matches, every address from 0x10 to 0x1F is written once, with all 16 bits of the stored word, to the same register address.
- R4: If the signature matches, an address from 0x2C to 0x33 is written only when bit 15 of its stored word is 1. A word with bit 15 at 0 leaves its register at its default.
- R5: Writes happen in strictly ascending address order: the 0x10–0x1F range first, then the 0x2C–0x33 range.
- R6: Each copied word is read exactly once, and its write strobe lasts one cycle, in the cycle right after its read. It uses the read address.
- R7: The loader reads only address 0x37 and the two copy ranges. It never reads at address 64 or above.
- R8: load_done is low while loading. Once high, it stays high until reset, and no further reads or writes occur.
- R9: A synchronous active-high reset, even in the middle of a load, lowers load_done and restarts the whole sequence from the signature read.
- R10: Counting rising edges after reset is released, load_done is high after the 3rd edge when the signature fails and after the 51st edge when it matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; restarts the load |
| mem_rd_en | output | 1 | Read request to the nonvolatile memory |
| mem_rd_addr | output | 8 | Memory word address for the read |
| mem_rd_data | input | 16 | Memory read data, valid one cycle after the request |
| reg_wr_en | output | 1 | One-cycle write strobe to the working registers |
| reg_wr_addr | output | 8 | Working register address, equal to the source address |
| reg_wr_data | output | 16 | Full 16-bit word to write |
| load_done | output | 1 | High once loading is finished or skipped; held until reset |

## Verification
The bench builds the block with its default parameters: an 8-bit address, 16-bit words, the signature 0xAA55 at 0x37 and the two copy ranges. These are the values at which the cycle counts of R10 and the range hand-off from 0x1F to 0x2C can be checked exactly. Random memory images with random flag bits are mixed with directed images: flags all set, flags all clear, signatures that differ by one bit or are byte-swapped, and a reset that arrives in the middle of a copy. Together they cover both outcomes of the signature and both outcomes of each flagged word.

// File: rtl/nvl_pkg.sv
package nvl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SIG_REQ = 3'd1,
        ST_SIG_CHK = 3'd2,
        ST_CP_REQ  = 3'd3,
        ST_CP_WR   = 3'd4,
        ST_DONE    = 3'd5
    } nvl_state_e;
endpackage

// File: rtl/nvl_addr_step.sv
// Walks the copy address: ascending through the fixed range, then jumps
// to the flagged range, and reports the last word of the walk.
module nvl_addr_step #(
    parameter int unsigned AW = 8,
    parameter logic [AW-1:0] FIX_LO = 8'h10,
    parameter logic [AW-1:0] FIX_HI = 8'h1F,
    parameter logic [AW-1:0] FLG_LO = 8'h2C,
    parameter logic [AW-1:0] FLG_HI = 8'h33
) (
    input  logic [AW-1:0] cur_addr,
    output logic [AW-1:0] nxt_addr,
    output logic          is_last
);
    always_comb begin
        if (cur_addr == FIX_HI) nxt_addr = FLG_LO;
        else                    nxt_addr = cur_addr + 1'b1;
        is_last = (cur_addr == FLG_HI);
    end
endmodule

// File: rtl/nvl_word_gate.sv
// Decides whether a word just read is copied: always in the fixed range,
// only with its flag bit set in the flagged range, never elsewhere.
module nvl_word_gate #(
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 16,
    parameter int unsigned FLAG_BIT = 15,
    parameter logic [AW-1:0] FIX_LO = 8'h10,
    parameter logic [AW-1:0] FIX_HI = 8'h1F,
    parameter logic [AW-1:0] FLG_LO = 8'h2C,
    parameter logic [AW-1:0] FLG_HI = 8'h33
) (
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] word,
    output logic          take
);
    logic in_fix, in_flg;
    always_comb begin
        in_fix = (addr >= FIX_LO) && (addr <= FIX_HI);
        in_flg = (addr >= FLG_LO) && (addr <= FLG_HI);
        take   = in_fix || (in_flg && word[FLAG_BIT]);
    end
endmodule

// File: rtl/nv_boot_loader.sv
module nv_boot_loader
    import nvl_pkg::*;
#(
    parameter int unsigned AW        = 8,
    parameter int unsigned DW        = 16,
    parameter int unsigned CFG_WORDS = 64,
    parameter int unsigned FLAG_BIT  = 15,
    parameter logic [AW-1:0] SIG_ADDR = 8'h37,
    parameter logic [DW-1:0] SIG_CODE = 16'hAA55,
    parameter logic [AW-1:0] FIX_LO   = 8'h10,
    parameter logic [AW-1:0] FIX_HI   = 8'h1F,
    parameter logic [AW-1:0] FLG_LO   = 8'h2C,
    parameter logic [AW-1:0] FLG_HI   = 8'h33
) (
    input  logic          clk,
    input  logic          rst,
    output logic          mem_rd_en,
    output logic [AW-1:0] mem_rd_addr,
    input  logic [DW-1:0] mem_rd_data,
    output logic          reg_wr_en,
    output logic [AW-1:0] reg_wr_addr,
    output logic [DW-1:0] reg_wr_data,
    output logic          load_done
);
    localparam logic [AW-1:0] CFG_LIMIT = AW'(CFG_WORDS);

    nvl_state_e    state, state_nx;
    logic [AW-1:0] cur_addr, step_addr;
    logic          step_last, word_take, sig_match, sig_seen;

    nvl_addr_step #(
        .AW(AW), .FIX_LO(FIX_LO), .FIX_HI(FIX_HI),
        .FLG_LO(FLG_LO), .FLG_HI(FLG_HI)
    ) i_step (
        .cur_addr(cur_addr),
        .nxt_addr(step_addr),
        .is_last (step_last)
    );

    nvl_word_gate #(
        .AW(AW), .DW(DW), .FLAG_BIT(FLAG_BIT),
        .FIX_LO(FIX_LO), .FIX_HI(FIX_HI),
        .FLG_LO(FLG_LO), .FLG_HI(FLG_HI)
    ) i_gate (
        .addr(cur_addr),
        .word(mem_rd_data),
        .take(word_take)
    );

    assign sig_match = (mem_rd_data == SIG_CODE);

    // State register and address counter
    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cur_addr <= FIX_LO;
            sig_seen <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_SIG_CHK && sig_match) sig_seen <= 1'b1;
            if (state == ST_CP_WR) cur_addr <= step_addr;
        end
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    state_nx = ST_SIG_REQ;
            ST_SIG_REQ: state_nx = ST_SIG_CHK;
            ST_SIG_CHK: state_nx = sig_match ? ST_CP_REQ : ST_DONE;
            ST_CP_REQ:  state_nx = ST_CP_WR;
            ST_CP_WR:   state_nx = step_last ? ST_DONE : ST_CP_REQ;
            ST_DONE:    state_nx = ST_DONE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        mem_rd_en   = 1'b0;
        mem_rd_addr = cur_addr;
        reg_wr_en   = 1'b0;
        reg_wr_addr = cur_addr;
        reg_wr_data = mem_rd_data;
        load_done   = 1'b0;
        unique case (state)
            ST_IDLE:    ;
            ST_SIG_REQ: begin
                mem_rd_en   = 1'b1;
                mem_rd_addr = SIG_ADDR;
            end
            ST_SIG_CHK: ;
            ST_CP_REQ:  mem_rd_en = 1'b1;
            ST_CP_WR:   reg_wr_en = word_take;
            ST_DONE:    load_done = 1'b1;
            default:    ;
        endcase
    end

    // Writes only after a matching signature has been seen (R1, R2)
    p_wr_after_sig_r1: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en |-> sig_seen);

    // Flagged-range writes carry their flag bit (R4)
    p_flag_gate_r4: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && reg_wr_addr >= FLG_LO && reg_wr_addr <= FLG_HI)
            |-> reg_wr_data[FLAG_BIT]);

    // Each write follows its own read by one cycle (R6)
    p_wr_follows_rd_r6: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en |-> ($past(mem_rd_en) && $past(mem_rd_addr) == reg_wr_addr));

    // Reads stay in the configuration area (R7)
    p_rd_in_cfg_r7: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> (mem_rd_addr < CFG_LIMIT));

    // Done is sticky and quiet (R8)
    p_done_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        load_done |=> load_done);
    p_done_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        load_done |-> (!mem_rd_en && !reg_wr_en));

    // Reset restarts with done low (R9)
    p_reset_clears_r9: assert property (@(posedge clk)
        $past(rst) |-> (!load_done && !reg_wr_en));
endmodule

// File: tb/test_nv_boot_loader.sv
module test_nv_boot_loader;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mem_rd_en;
    logic [7:0]  mem_rd_addr;
    logic [15:0] mem_rd_data = 16'h0;
    logic        reg_wr_en;
    logic [7:0]  reg_wr_addr;
    logic [15:0] reg_wr_data;
    logic        load_done;

    logic [15:0] mem  [0:255];
    logic [15:0] wreg [0:255];

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // monitor state
    int          n_rd, n_wr;
    logic [7:0]  first_rd, max_rd, last_wr;
    logic        prev_rd;
    logic [7:0]  prev_rd_addr;
    int          pair_err, order_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    nv_boot_loader i_nv_boot_loader (
        .clk(clk), .rst(rst),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .load_done(load_done)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (reg_wr_en) begin
                if (!(prev_rd && prev_rd_addr == reg_wr_addr)) pair_err++;
                if (n_wr > 0 && reg_wr_addr <= last_wr) order_err++;
                if (n_rd == 0) pair_err++;
                last_wr = reg_wr_addr;
                wreg[reg_wr_addr] = reg_wr_data;
                n_wr++;
            end
            if (mem_rd_en) begin
                if (n_rd == 0) first_rd = mem_rd_addr;
                if (mem_rd_addr > max_rd) max_rd = mem_rd_addr;
                n_rd++;
            end
            prev_rd      = mem_rd_en;
            prev_rd_addr = mem_rd_addr;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        fails++; checks++;
        $display("FAIL watchdog: run did not end, actual=%0d cycles expected<150000", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    function automatic logic [15:0] dflt(input int a);
        return 16'h5000 ^ 16'(a);
    endfunction

    function automatic bit in_fix(input int a);
        return a >= 8'h10 && a <= 8'h1F;
    endfunction

    function automatic bit in_flg(input int a);
        return a >= 8'h2C && a <= 8'h33;
    endfunction

    function automatic logic [15:0] expect_reg(input int a);
        if (mem[8'h37] != 16'hAA55) return dflt(a);
        if (in_fix(a)) return mem[a];
        if (in_flg(a) && mem[a][15]) return mem[a];
        return dflt(a);
    endfunction

    function automatic int expect_writes();
        int n;
        if (mem[8'h37] != 16'hAA55) return 0;
        n = 16;
        for (int a = 8'h2C; a <= 8'h33; a++) if (mem[a][15]) n++;
        return n;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic fill_mem(input logic [15:0] sig, input int flag_mode);
        for (int a = 0; a < 256; a++) mem[a] = 16'($urandom);
        for (int a = 8'h2C; a <= 8'h33; a++) begin
            if (flag_mode == 1) mem[a][15] = 1'b1;
            if (flag_mode == 2) mem[a][15] = 1'b0;
        end
        mem[8'h37] = sig;
    endtask

    task automatic clear_mon();
        n_rd = 0; n_wr = 0; first_rd = 8'h0; max_rd = 8'h0; last_wr = 8'h0;
        prev_rd = 1'b0; prev_rd_addr = 8'h0; pair_err = 0; order_err = 0;
        for (int a = 0; a < 256; a++) wreg[a] = dflt(a);
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        // R9: reset state
        check(!load_done && !reg_wr_en && !mem_rd_en, "R9 reset state",
              {load_done, reg_wr_en, mem_rd_en}, 0);
        clear_mon();
        rst = 1'b0;
    endtask

    task automatic run_load(input string tag);
        int n;
        bit sig_ok;
        int bad;
        sig_ok = (mem[8'h37] == 16'hAA55);
        apply_reset();
        n = 0;
        while (!load_done && n < 1000) begin
            @(negedge clk);
            n++;
        end
        // R10: completion cycle
        check(n == (sig_ok ? 51 : 3), "R10 done timing", n, sig_ok ? 51 : 3);
        // R1: first read is the signature
        check(first_rd == 8'h37, "R1 first read address", first_rd, 8'h37);
        // R6: one read per word, each write paired with its read
        check(n_rd == (sig_ok ? 25 : 1), "R6 read count", n_rd, sig_ok ? 25 : 1);
        check(pair_err == 0, "R6 write follows read", pair_err, 0);
        // R7: reads inside configuration area
        check(max_rd < 8'd64, "R7 highest read address", max_rd, 63);
        // R5: ascending order
        check(order_err == 0, "R5 write order", order_err, 0);
        // R2 / R3 / R4: write count and register contents
        check(n_wr == expect_writes(), sig_ok ? "R3 R4 write count" : "R2 no writes",
              n_wr, expect_writes());
        bad = 0;
        for (int a = 8'h10; a <= 8'h1F; a++)
            if (wreg[a] !== expect_reg(a)) begin
                bad++;
                check(0, "R3 fixed range word", wreg[a], expect_reg(a));
            end
        for (int a = 8'h2C; a <= 8'h33; a++)
            if (wreg[a] !== expect_reg(a)) begin
                bad++;
                check(0, "R4 flagged range word", wreg[a], expect_reg(a));
            end
        for (int a = 0; a < 256; a++)
            if (!in_fix(a) && !in_flg(a) && wreg[a] !== dflt(a)) begin
                bad++;
                check(0, "R3 untouched register", wreg[a], dflt(a));
            end
        check(bad == 0, sig_ok ? "R3 R4 register image" : "R2 registers at default", bad, 0);
        // R8: sticky and quiet after done
        n = n_rd + n_wr;
        repeat (12) @(negedge clk);
        check(load_done && (n_rd + n_wr) == n, "R8 done held, no activity",
              {31'(n_rd + n_wr - n), load_done}, 1);
        $display("run %s: %0d writes", tag, n_wr);
    endtask

    initial begin
        void'($urandom(32'd1409));
        clear_mon();
        repeat (3) @(negedge clk);

        // directed: flags all set, all clear
        fill_mem(16'hAA55, 1); run_load("flags set");
        fill_mem(16'hAA55, 2); run_load("flags clear");
        // directed: near-miss signatures
        fill_mem(16'hAA54, 1); run_load("sig one bit off");
        fill_mem(16'h55AA, 1); run_load("sig swapped");
        fill_mem(16'h0000, 0); run_load("sig blank");

        // R9: reset in the middle of a copy, then a full restart
        fill_mem(16'hAA55, 0);
        apply_reset();
        repeat (20) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(!load_done, "R9 mid-load reset lowers done", load_done, 0);
        run_load("restart after mid reset");

        // random images
        for (int i = 0; i < 8; i++) begin
            fill_mem(($urandom % 4 == 0) ? 16'($urandom) : 16'hAA55, 0);
            run_load("random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule